// File: doc/BRIEF.md
# Extraction Stream Word Decoder

This block sits behind a CPU extraction queue of a switch. It takes the queue's 32-bit words one at a time and rebuilds a single frame from them. The first words of every frame form a fixed-length internal header. The block passes these words out unchanged and indexed, without looking for control codes in them. After the header, the block tells plain data words apart from control codes carried in the same 32-bit space. It sends the data words on with a valid and a last marker, keeps a running byte count, and closes the frame with a one-cycle done pulse and an outcome.

Control codes are words with bit 31 set, bits 30..3 clear, and a 3-bit code in bits 2..0. An escape code forces the next word to be literal data. The end-of-frame codes carry, in their low two bits, how many bytes of the final data word are unused. A configuration input says whether the queue delivers words byte-reversed. In that case codes are recognised on the byte-reversed word, while the data itself is passed on exactly as received.

Top module: `xtr_stream_decoder`

## Requirements
- R1: The first HDR_WORDS accepted words of each frame appear on `hdr_valid`/`hdr_idx`/`hdr_word` one cycle after acceptance, with index 0 upward. They are never decoded as codes and never produce data output.
- R2: A body word that is not a code (bit 31 clear, or bits 30..3 not all zero) adds 4 to the byte count and is delivered unaltered. It is held back and goes out one cycle after the next data word is accepted, or with `dat_last`=1 in the cycle `done` pulses.
- R3: Codes 0..3 (0x80000000..0x80000003) close the frame. The count is reduced by bits 1..0 of the code, and it cannot go below zero.
- R4: Code 4 (0x80000004) makes the next accepted word data (+4 bytes). The frame then closes as pruned one cycle after that word's own close point, so `done` comes two cycles after the word is accepted.
- R5: Code 5 (0x80000005) closes the frame at once as aborted, with the count unchanged and no data word attached.
- R6: Code 6 (0x80000006) makes the next accepted word plain data, even when its value equals a code.
- R7: Code 7 (0x80000007) is ignored. The count, the outputs and the decoding state all stay as they were.
- R8: With `swap_en`=1, codes are matched against the word with its four bytes reversed. Delivered data is always the word as received.
- R9: `done` is high for exactly one cycle per frame, one cycle after the closing word, with exactly one of good/abort/pruned/incomplete set. Good means an end-of-frame code with a final count of at least FCS_BYTES. `frame_len` is the count minus FCS_BYTES when good, and 0 otherwise. Outside `done`, the flags, `byte_cnt` and `frame_len` read 0.
- R10: A data word that arrives after MAX_DATA_WORDS data words have already been taken closes the frame as incomplete. That word is dropped and the count is unchanged.
- R11: After a frame closes, the next accepted word is header word 0 of a new frame. This is also the case in the cycle where a deferred pruned close completes.
- R12: While reset is active and just after it, all valid, done and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Match codes on byte-reversed words |
| in_valid | input | 1 | A word is presented this cycle |
| in_data | input | WORD_W | Word read from the extraction queue |
| hdr_valid | output | 1 | Header word output valid |
| hdr_idx | output | HIDX_W | Position of the header word |
| hdr_word | output | WORD_W | Header word as received |
| dat_valid | output | 1 | Frame data word valid |
| dat_word | output | WORD_W | Frame data word as received |
| dat_last | output | 1 | Final data word of the frame |
| done | output | 1 | One-cycle frame close pulse |
| byte_cnt | output | CNT_W | Final byte count, valid with done |
| frame_len | output | CNT_W | Count less FCS for good frames |
| st_good | output | 1 | Frame ended by end-of-frame code |
| st_abort | output | 1 | Frame ended by abort code |
| st_pruned | output | 1 | Frame ended by pruned code |
| st_incomplete | output | 1 | Word limit exceeded or count below FCS |

## Verification
The assertions take any sequence of words on `in_data`. They rely on HDR_WORDS being at least 2, so that two closes can never fall in adjacent cycles. They also rely on `swap_en` being sampled in the same cycle as the word it applies to. The stimulus keeps the header length at 3 and the word limit small. It changes `swap_en` only between long word runs, not inside a word's cycle. It mixes directed frames that place codes in headers, escaped code values and back-to-back frames after a pruned close with a pseudo-random stream in which codes, gaps and data are interleaved.

// File: rtl/xsd_pkg.sv
package xsd_pkg;
   typedef enum logic [2:0] {
      K_DATA,
      K_EOF,
      K_PRUNE,
      K_ABORT,
      K_ESC,
      K_IDLE
   } code_kind_t;

   typedef enum logic [1:0] {
      S_HDR,
      S_BODY,
      S_LIT
   } dec_state_t;
endpackage

// File: rtl/xsd_code_classify.sv
module xsd_code_classify
   import xsd_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] raw_i,
   input  logic              swap_i,
   output code_kind_t        kind_o,
   output logic [1:0]        unused_o
);
   localparam int NBYTES = WORD_W / 8;

   logic [WORD_W-1:0] rev_w;
   logic [WORD_W-1:0] cmp_w;
   logic              is_code;

   if (WORD_W != 32) begin : g_bad_width
      $error("xsd_code_classify: WORD_W must be 32");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_rev
      assign rev_w[8*b +: 8] = raw_i[8*(NBYTES-1-b) +: 8];
   end

   assign cmp_w   = swap_i ? rev_w : raw_i;
   assign is_code = cmp_w[WORD_W-1] && (cmp_w[WORD_W-2:3] == '0);

   always_comb begin
      kind_o = K_DATA;
      if (is_code) begin
         case (cmp_w[2:0])
            3'd4:    kind_o = K_PRUNE;
            3'd5:    kind_o = K_ABORT;
            3'd6:    kind_o = K_ESC;
            3'd7:    kind_o = K_IDLE;
            default: kind_o = K_EOF;
         endcase
      end
   end

   assign unused_o = cmp_w[1:0];
endmodule

// File: rtl/xsd_word_hold.sv
module xsd_word_hold #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [WORD_W-1:0] push_data_i,
   input  logic              flush_i,
   output logic              o_valid,
   output logic              o_last,
   output logic [WORD_W-1:0] o_data
);
   logic              hold_v;
   logic [WORD_W-1:0] hold_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         hold_d  <= '0;
         o_valid <= 1'b0;
         o_last  <= 1'b0;
         o_data  <= '0;
      end else begin
         o_valid <= 1'b0;
         o_last  <= 1'b0;
         if (flush_i) begin
            o_valid <= hold_v;
            o_last  <= hold_v;
            o_data  <= hold_d;
            hold_v  <= 1'b0;
         end else if (push_i) begin
            o_valid <= hold_v;
            o_data  <= hold_d;
            hold_d  <= push_data_i;
            hold_v  <= 1'b1;
         end
      end
   end

   AST_HOLD_EMIT: assert property (@(posedge clk) disable iff (!rst_n) (push_i && !flush_i && hold_v) |=> (o_valid && !o_last)); // R2
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush_i |=> !hold_v); // R2
endmodule

// File: rtl/xtr_stream_decoder.sv
module xtr_stream_decoder
   import xsd_pkg::*;
#(
   parameter int WORD_W         = 32,
   parameter int HDR_WORDS      = 9,
   parameter int MAX_DATA_WORDS = 512,
   parameter int FCS_BYTES      = 4,
   localparam int HIDX_W        = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
   localparam int WC_W          = $clog2(MAX_DATA_WORDS + 1),
   localparam int CNT_W         = $clog2(MAX_DATA_WORDS * 4 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_en,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              hdr_valid,
   output logic [HIDX_W-1:0] hdr_idx,
   output logic [WORD_W-1:0] hdr_word,
   output logic              dat_valid,
   output logic [WORD_W-1:0] dat_word,
   output logic              dat_last,
   output logic              done,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic [CNT_W-1:0]  frame_len,
   output logic              st_good,
   output logic              st_abort,
   output logic              st_pruned,
   output logic              st_incomplete
);
   if (HDR_WORDS < 2) begin : g_bad_hdr
      $error("xtr_stream_decoder: HDR_WORDS must be at least 2");
   end
   if (MAX_DATA_WORDS < 2) begin : g_bad_max
      $error("xtr_stream_decoder: MAX_DATA_WORDS must be at least 2");
   end
   if (FCS_BYTES > 4 * MAX_DATA_WORDS) begin : g_bad_fcs
      $error("xtr_stream_decoder: FCS_BYTES exceeds frame capacity");
   end

   localparam logic [HIDX_W-1:0] HIDX_LAST = HIDX_W'(HDR_WORDS - 1);
   localparam logic [WC_W-1:0]   WC_LIMIT  = WC_W'(MAX_DATA_WORDS);
   localparam logic [CNT_W-1:0]  FCS_C     = CNT_W'(FCS_BYTES);

   code_kind_t        kind;
   logic [1:0]        unused;
   dec_state_t        state, nxt_state;
   logic [HIDX_W-1:0] hidx;
   logic [WC_W-1:0]   word_cnt;
   logic [CNT_W-1:0]  run_cnt, fin_cnt, unused_ext;
   logic              lit_prune, set_litprune;
   logic              close_pend, set_pend;
   logic              push, hdr_take, close;
   logic              c_eof, c_abort, c_prune, c_limit;
   logic              out_good, out_incomp, at_limit;

   xsd_code_classify #(.WORD_W(WORD_W)) classify_i (
      .raw_i    (in_data),
      .swap_i   (swap_en),
      .kind_o   (kind),
      .unused_o (unused)
   );

   xsd_word_hold #(.WORD_W(WORD_W)) hold_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i (in_data),
      .flush_i     (close),
      .o_valid     (dat_valid),
      .o_last      (dat_last),
      .o_data      (dat_word)
   );

   assign unused_ext = {{(CNT_W-2){1'b0}}, unused};
   assign at_limit   = (word_cnt == WC_LIMIT);

   always_comb begin
      nxt_state    = state;
      push         = 1'b0;
      hdr_take     = 1'b0;
      close        = 1'b0;
      c_eof        = 1'b0;
      c_abort      = 1'b0;
      c_prune      = 1'b0;
      c_limit      = 1'b0;
      set_pend     = 1'b0;
      set_litprune = lit_prune;
      fin_cnt      = run_cnt;
      if (close_pend) begin
         close   = 1'b1;
         c_prune = 1'b1;
      end
      if (in_valid) begin
         case (state)
            S_HDR: begin
               hdr_take = 1'b1;
               if (hidx == HIDX_LAST) nxt_state = S_BODY;
            end
            S_BODY: begin
               case (kind)
                  K_DATA: begin
                     if (at_limit) begin
                        close     = 1'b1;
                        c_limit   = 1'b1;
                        nxt_state = S_HDR;
                     end else begin
                        push = 1'b1;
                     end
                  end
                  K_EOF: begin
                     close     = 1'b1;
                     c_eof     = 1'b1;
                     nxt_state = S_HDR;
                     fin_cnt   = (run_cnt < unused_ext) ? '0 : run_cnt - unused_ext;
                  end
                  K_PRUNE: begin
                     nxt_state    = S_LIT;
                     set_litprune = 1'b1;
                  end
                  K_ESC: begin
                     nxt_state    = S_LIT;
                     set_litprune = 1'b0;
                  end
                  K_ABORT: begin
                     close     = 1'b1;
                     c_abort   = 1'b1;
                     nxt_state = S_HDR;
                  end
                  default: ;
               endcase
            end
            S_LIT: begin
               if (at_limit) begin
                  close     = 1'b1;
                  c_limit   = 1'b1;
                  nxt_state = S_HDR;
               end else begin
                  push = 1'b1;
                  if (lit_prune) begin
                     set_pend  = 1'b1;
                     nxt_state = S_HDR;
                  end else begin
                     nxt_state = S_BODY;
                  end
               end
            end
            default: nxt_state = S_HDR;
         endcase
      end
   end

   assign out_good   = c_eof && (fin_cnt >= FCS_C);
   assign out_incomp = c_limit || (c_eof && !out_good);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= S_HDR;
         hidx          <= '0;
         word_cnt      <= '0;
         run_cnt       <= '0;
         lit_prune     <= 1'b0;
         close_pend    <= 1'b0;
         hdr_valid     <= 1'b0;
         hdr_idx       <= '0;
         hdr_word      <= '0;
         done          <= 1'b0;
         byte_cnt      <= '0;
         frame_len     <= '0;
         st_good       <= 1'b0;
         st_abort      <= 1'b0;
         st_pruned     <= 1'b0;
         st_incomplete <= 1'b0;
      end else begin
         state      <= nxt_state;
         lit_prune  <= set_litprune;
         close_pend <= set_pend;
         if (hdr_take) hidx <= (hidx == HIDX_LAST) ? '0 : hidx + 1'b1;
         if (close) begin
            run_cnt  <= '0;
            word_cnt <= '0;
         end else if (push) begin
            run_cnt  <= run_cnt + CNT_W'(4);
            word_cnt <= word_cnt + 1'b1;
         end
         hdr_valid <= hdr_take;
         if (hdr_take) begin
            hdr_idx  <= hidx;
            hdr_word <= in_data;
         end
         done          <= close;
         byte_cnt      <= close ? fin_cnt : '0;
         frame_len     <= (close && out_good) ? fin_cnt - FCS_C : '0;
         st_good       <= close && out_good;
         st_abort      <= close && c_abort;
         st_pruned     <= close && c_prune;
         st_incomplete <= close && out_incomp;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($countones({st_good, st_abort, st_pruned, st_incomplete}) == 1)); // R9
   AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ({st_good, st_abort, st_pruned, st_incomplete} == 4'b0)); // R9
   AST_LEN_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && !st_good) |-> (frame_len == '0)); // R9
   AST_LAST_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) (dat_valid && dat_last) |-> done); // R2
   AST_HDR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (state == S_HDR && !close_pend) |=> !dat_valid); // R1
   AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && state == S_BODY && kind == K_IDLE) |=> $stable(run_cnt)); // R7
   AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) word_cnt <= WC_LIMIT); // R10
   AST_PUSH_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(push && close)); // R4
   AST_ABORT_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && state == S_BODY && kind == K_ABORT) |=> (done && st_abort && byte_cnt == $past(run_cnt))); // R5
endmodule

// File: tb/xtr_stream_decoder_tb_top.sv
`timescale 1ns/1ps
module xtr_stream_decoder_tb_top;
   localparam int HDR  = 3;
   localparam int MAXW = 8;
   localparam int HIW  = 2;
   localparam int CW   = $clog2(MAXW * 4 + 1);

   logic          clk = 1'b0, rst_n = 1'b0, swap_en = 1'b0, in_valid = 1'b0;
   logic [31:0]   in_data = '0;
   logic          hdr_valid, dat_valid, dat_last, done;
   logic [HIW-1:0] hdr_idx;
   logic [31:0]   hdr_word, dat_word;
   logic [CW-1:0] byte_cnt, frame_len;
   logic          st_good, st_abort, st_pruned, st_incomplete;

   int checks = 0, failed = 0, cyc = 0;

   always #2 clk = ~clk;

   xtr_stream_decoder #(.WORD_W(32), .HDR_WORDS(HDR), .MAX_DATA_WORDS(MAXW), .FCS_BYTES(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .in_valid(in_valid), .in_data(in_data),
      .hdr_valid(hdr_valid), .hdr_idx(hdr_idx), .hdr_word(hdr_word),
      .dat_valid(dat_valid), .dat_word(dat_word), .dat_last(dat_last),
      .done(done), .byte_cnt(byte_cnt), .frame_len(frame_len),
      .st_good(st_good), .st_abort(st_abort), .st_pruned(st_pruned), .st_incomplete(st_incomplete)
   );

   function automatic logic [31:0] brev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   // Behavioural reference: phase 0 header, 1 body, 2 literal word pending
   int m_phase, m_hidx, m_litp, m_pend, m_bytes, m_words, m_hv;
   logic [31:0] m_held;
   int e_hv, e_hidx, e_dv, e_last, e_done, e_oc, e_cnt, e_len;
   logic [31:0] e_hdata, e_dword;

   always @(posedge clk) begin : model
      int closing, oc, fcnt;
      logic [31:0] cmp;
      bit iscode;
      if (!rst_n) begin
         m_phase = 0; m_hidx = 0; m_litp = 0; m_pend = 0; m_bytes = 0; m_words = 0; m_hv = 0; m_held = '0;
         e_hv = 0; e_hidx = 0; e_dv = 0; e_last = 0; e_done = 0; e_oc = -1; e_cnt = 0; e_len = 0;
         e_hdata = '0; e_dword = '0;
      end else begin
         e_hv = 0; e_dv = 0; e_last = 0; e_done = 0; e_oc = -1; e_cnt = 0; e_len = 0;
         closing = 0; oc = 0; fcnt = m_bytes;
         if (m_pend != 0) begin closing = 1; oc = 2; m_pend = 0; end
         if (in_valid) begin
            if (m_phase == 0) begin
               e_hv = 1; e_hidx = m_hidx; e_hdata = in_data;
               m_hidx++;
               if (m_hidx == HDR) begin m_hidx = 0; m_phase = 1; end
            end else begin
               cmp = swap_en ? brev(in_data) : in_data;
               iscode = cmp[31] && (cmp[30:3] == '0);
               if (m_phase == 2 || !iscode) begin
                  if (m_words == MAXW) begin
                     closing = 1; oc = 3; m_phase = 0;
                  end else begin
                     if (m_hv != 0) begin e_dv = 1; e_dword = m_held; end
                     m_held = in_data; m_hv = 1; m_words++; m_bytes += 4;
                     if (m_phase == 2 && m_litp != 0) begin m_pend = 1; m_phase = 0; end
                     else m_phase = 1;
                  end
               end else begin
                  case (int'(cmp[2:0]))
                     0, 1, 2, 3: begin
                        closing = 1; m_phase = 0;
                        fcnt = (m_bytes < int'(cmp[1:0])) ? 0 : m_bytes - int'(cmp[1:0]);
                        oc = (fcnt >= 4) ? 0 : 3;
                     end
                     4: begin m_phase = 2; m_litp = 1; end
                     5: begin closing = 1; oc = 1; m_phase = 0; end
                     6: begin m_phase = 2; m_litp = 0; end
                     default: ;
                  endcase
               end
            end
         end
         if (closing != 0) begin
            e_done = 1; e_oc = oc; e_cnt = fcnt; e_len = (oc == 0) ? fcnt - 4 : 0;
            if (m_hv != 0) begin e_dv = 1; e_dword = m_held; e_last = 1; end
            m_hv = 0; m_bytes = 0; m_words = 0;
         end
      end
   end

   // Per-cycle comparison against the reference, plus capture for directed checks
   int cap_n = 0, cap_cnt = 0, cap_len = 0, cap_oc = -1;
   logic [31:0] cap_word = '0;

   always @(negedge clk) begin
      int got_oc;
      got_oc = st_good ? 0 : st_abort ? 1 : st_pruned ? 2 : st_incomplete ? 3 : -1;
      if (rst_n) begin
         checks++;
         if (hdr_valid !== 1'(e_hv) || (e_hv != 0 && (hdr_idx !== HIW'(e_hidx) || hdr_word !== e_hdata))) begin
            failed++;
            $display("FAIL R1 cycle %0d: hdr v=%0b idx=%0d w=%h expected v=%0d idx=%0d w=%h",
                     cyc, hdr_valid, hdr_idx, hdr_word, e_hv, e_hidx, e_hdata);
         end else if (dat_valid !== 1'(e_dv) || dat_last !== 1'(e_last) || (e_dv != 0 && dat_word !== e_dword)) begin
            failed++;
            $display("FAIL R2 cycle %0d: dat v=%0b last=%0b w=%h expected v=%0d last=%0d w=%h",
                     cyc, dat_valid, dat_last, dat_word, e_dv, e_last, e_dword);
         end else if (done !== 1'(e_done) || got_oc != e_oc || int'(byte_cnt) != e_cnt || int'(frame_len) != e_len
                      || $countones({st_good, st_abort, st_pruned, st_incomplete}) > 1) begin
            failed++;
            $display("FAIL R9 cycle %0d: done=%0b oc=%0d cnt=%0d len=%0d expected done=%0d oc=%0d cnt=%0d len=%0d",
                     cyc, done, got_oc, byte_cnt, frame_len, e_done, e_oc, e_cnt, e_len);
         end
         if (done) begin cap_n++; cap_cnt = int'(byte_cnt); cap_len = int'(frame_len); cap_oc = got_oc; end
         if (dat_valid) cap_word = dat_word;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failed++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", checks, failed);
         $finish;
      end
   end

   task automatic put(input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = 32'hDEAD_BEEF;
      end
   endtask

   task automatic hdr3();
      put(32'h8000_0005); // header words shaped like codes: must not be decoded (R1)
      put(32'h8000_0000);
      put(32'h1234_0001);
   endtask

   int fr_exp = 0;

   task automatic chk_frame(input string tag, input int cnt, input int len, input int oc);
      checks++;
      if (cap_n != fr_exp || cap_cnt != cnt || cap_len != len || cap_oc != oc) begin
         failed++;
         $display("FAIL %s: frames=%0d cnt=%0d len=%0d oc=%0d expected frames=%0d cnt=%0d len=%0d oc=%0d",
                  tag, cap_n, cap_cnt, cap_len, cap_oc, fr_exp, cnt, len, oc);
      end
   endtask

   task automatic chk_word(input string tag, input logic [31:0] exp);
      checks++;
      if (cap_word !== exp) begin
         failed++;
         $display("FAIL %s: last data word %h expected %h", tag, cap_word, exp);
      end
   endtask

   initial begin : stim
      logic [31:0] r;
      // R12: reset state
      repeat (3) @(negedge clk);
      checks++;
      if ({hdr_valid, dat_valid, dat_last, done, st_good, st_abort, st_pruned, st_incomplete} !== 8'b0) begin
         failed++;
         $display("FAIL R12: outputs not idle in reset (%b) expected 0",
                  {hdr_valid, dat_valid, dat_last, done, st_good, st_abort, st_pruned, st_incomplete});
      end
      rst_n = 1'b1;
      idle(2);
      checks++;
      if ({hdr_valid, dat_valid, done} !== 3'b0) begin
         failed++;
         $display("FAIL R12: outputs after reset %b expected 000", {hdr_valid, dat_valid, done});
      end

      // R3 R1: three data words then EOF with 2 unused bytes -> 10 bytes, len 6
      hdr3(); put(32'h1111_1111); put(32'h2222_2222); put(32'h3333_3333); put(32'h8000_0002); idle(3);
      fr_exp++; chk_frame("R3", 10, 6, 0); chk_word("R2", 32'h3333_3333);

      // R6: escaped abort value is data
      hdr3(); put(32'h8000_0006); put(32'h8000_0005); put(32'h1234_5678); put(32'h8000_0000); idle(3);
      fr_exp++; chk_frame("R6", 8, 4, 0); chk_word("R6", 32'h1234_5678);

      // R7: not-ready code ignored, with input gaps in between
      hdr3(); put(32'hAAAA_0001); put(32'h8000_0007); idle(2); put(32'h8000_0007); put(32'hBBBB_0002); put(32'h8000_0001); idle(3);
      fr_exp++; chk_frame("R7", 7, 3, 0);

      // R5: abort keeps count
      hdr3(); put(32'h0000_0042); put(32'h8000_0005); idle(3);
      fr_exp++; chk_frame("R5", 4, 0, 1);

      // R4: pruned takes next word (a code value) as data, deferred close
      hdr3(); put(32'h5555_5555); put(32'h8000_0004); put(32'h8000_0003); idle(4);
      fr_exp++; chk_frame("R4", 8, 0, 2); chk_word("R4", 32'h8000_0003);

      // R8: byte-swapped matching; raw 0x80000000 is data under swap
      swap_en = 1'b1;
      hdr3(); put(32'h8000_0000); put(32'hAABB_CCDD); put(32'h0700_0080); put(32'h0200_0080); idle(3);
      fr_exp++; chk_frame("R8", 6, 2, 0); chk_word("R8", 32'hAABB_CCDD);
      swap_en = 1'b0;

      // R10: ninth data word exceeds the limit of 8
      hdr3(); for (int i = 0; i < 9; i++) put(32'h0100_0000 + i); idle(3);
      fr_exp++; chk_frame("R10", 32, 0, 3);

      // R9: EOF with 3 unused and no data -> count floors at 0, incomplete
      hdr3(); put(32'h8000_0003); idle(3);
      fr_exp++; chk_frame("R9", 0, 0, 3);
      // R9: exactly FCS bytes is good with length 0
      hdr3(); put(32'h7777_7777); put(32'h8000_0000); idle(3);
      fr_exp++; chk_frame("R9", 4, 0, 0);

      // R11: pruned frame followed at once by a new frame header
      hdr3(); put(32'h0000_0001); put(32'h8000_0004); put(32'h0000_0002);
      hdr3(); put(32'h0000_0003); put(32'h8000_0000); idle(3);
      fr_exp += 2; chk_frame("R11", 4, 0, 0);

      // Mixed pseudo-random stream, compared cycle by cycle (R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
      r = 32'h1F2E_3D4C;
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] w;
         int sel;
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         sel = int'(r[3:0]);
         if (n % 1000 == 0) swap_en = r[20];
         case (sel)
            10: w = 32'h8000_0000 | {30'b0, r[9:8]};
            11: w = 32'h8000_0006;
            12: w = 32'h8000_0007;
            13: w = 32'h8000_0004;
            14: w = r[11] ? 32'h8000_0005 : r;
            default: w = r;
         endcase
         if (sel >= 10 && sel <= 14 && swap_en) w = brev(w);
         if (sel == 15) idle(1);
         else put(w);
      end
      idle(5);
      $display("[TB] %0d tests run, %0d failed", checks, failed);
      $finish;
   end
endmodule